// File: doc/BRIEF.md
# Position and Revolution Counter Pair

This block keeps two 16-bit counts for a rotary or linear encoder. Single-cycle up and down pulses from a quadrature decoder move a position count. The position count wraps between zero and a programmable maximum. An index pulse, already edge-detected, can clear the position count, and it always marks a sticky zero-index flag. A second count, the revolution count, is stepped by the index pulse, by position wraps, by both, or by neither. A 2-bit revolution mode chooses among these four options.

Overflow, underflow and index events are latched in sticky flags. Software clears a flag by writing 0 to its bit through a one-cycle write strobe. When the revolution count follows position wraps, the block also gives a combined absolute position. The revolution mode, the clear-gate bit and the maximum are static configuration inputs.

Top module: `pos_rev_counter`

## Requirements
- R1: Reset sets position, revolution, direction (0 = up) and all flags to 0. In revolution modes 00, 10 and 11, an up pulse at position == maximum loads 0 and sets the overflow flag.
- R2: In every mode, a down pulse at position 0 loads the maximum and sets the underflow flag. Any other down pulse subtracts 1, and any other up pulse adds 1.
- R3: Mode 00 never changes the revolution count. With the clear gate high, an index pulse loads position 0.
- R4: In mode 01, an up pulse at the maximum still sets the overflow flag, but the position keeps counting upward and the revolution count does not change. With the clear gate high, an index pulse loads position 0 and steps the revolution count by the direction.
- R5: In mode 10, the index pulse changes neither count. An overflow adds 1 to the revolution count, and an underflow subtracts 1.
- R6: In mode 11, with the clear gate high, an index pulse loads position 0 and steps the revolution count by the direction. Overflow and underflow also step the revolution count.
- R7: An index pulse that clears the position discards any count pulse in the same cycle. The revolution step then follows that count pulse's direction, even if it is opposite to the stored one, and the stored direction takes the new value.
- R8: When the both-edges input is high, the count pulses are ignored. An index step in that cycle follows the stored direction. An up pulse and a down pulse together are also ignored.
- R9: The revolution count wraps from 0 to 0xFFFF on a decrement.
- R10: With the clear gate low, an index pulse only sets the zero-index flag. Both counts are unchanged.
- R11: The flags (write bit 0 overflow, bit 1 underflow, bit 2 zero-index) are sticky. A write strobe clears each flag whose data bit is 0. A set in the same cycle wins over the clear.
- R12: In modes 10 and 11, the absolute output equals position + revolution × (maximum + 1) as a 32-bit value. In modes 00 and 01, it equals the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_up_i | input | 1 | One-cycle up count pulse |
| cnt_dn_i | input | 1 | One-cycle down count pulse |
| ab_both_i | input | 1 | Edges on both encoder phases seen together |
| index_i | input | 1 | Edge-detected index pulse |
| rev_mode_i | input | 2 | Revolution mode: 00 off, 01 index, 10 wrap, 11 both |
| clr_gate_i | input | 1 | Lets the index pulse clear position and step revolution |
| max_pos_i | input | 16 | Position maximum |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 3 | Flag write data, 0 clears |
| pos_o | output | 16 | Position count |
| rev_o | output | 16 | Revolution count |
| abs_pos_o | output | 32 | Absolute position |
| dir_o | output | 1 | Last count direction, 1 = down |
| ovf_o | output | 1 | Overflow flag |
| unf_o | output | 1 | Underflow flag |
| zidx_o | output | 1 | Zero-index flag |

## Verification
The assertions check the following on every cycle:
- the wrap to 0 at the maximum and the reload of the maximum below 0;
- that mode 00 keeps the revolution count frozen;
- that mode 10 ignores an index pulse on its own;
- that the zero-index flag gets set;
- that the flags stay sticky until a clearing write.

Some behaviour needs exact sequences, so only the bench scenarios show it:
- the direction used when an index pulse meets an opposite count pulse or simultaneous phase edges;
- counting past the maximum in mode 01;
- the revolution wrap to 0xFFFF;
- the set-wins-over-clear case;
- the absolute position product.

// File: rtl/prc_pkg.sv
package prc_pkg;
    typedef enum logic [1:0] {
        REV_OFF   = 2'b00,
        REV_INDEX = 2'b01,
        REV_WRAP  = 2'b10,
        REV_BOTH  = 2'b11
    } rev_mode_e;

    localparam int FLAG_N   = 3;
    localparam int FLAG_OVF = 0;
    localparam int FLAG_UNF = 1;
    localparam int FLAG_ZIX = 2;
endpackage

// File: rtl/prc_pos_next.sv
module prc_pos_next #(
    parameter int W = 16
) (
    input  logic [W-1:0] pos_q,
    input  logic [W-1:0] max_pos,
    input  logic         step_up,
    input  logic         step_dn,
    input  logic         idx_clr,
    input  logic         run_past_max,
    output logic [W-1:0] pos_d,
    output logic         ovf,
    output logic         unf
);
    always_comb begin
        pos_d = pos_q;
        ovf   = 1'b0;
        unf   = 1'b0;
        if (idx_clr) begin
            pos_d = '0;
        end else if (step_up) begin
            if (pos_q == max_pos) begin
                ovf   = 1'b1;
                pos_d = run_past_max ? pos_q + 1'b1 : '0;
            end else begin
                pos_d = pos_q + 1'b1;
            end
        end else if (step_dn) begin
            if (pos_q == '0) begin
                unf   = 1'b1;
                pos_d = max_pos;
            end else begin
                pos_d = pos_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/prc_rev_next.sv
module prc_rev_next #(
    parameter int W = 16
) (
    input  logic [W-1:0] rev_q,
    input  logic         idx_step,
    input  logic         idx_down,
    input  logic         wrap_en,
    input  logic         ovf,
    input  logic         unf,
    output logic [W-1:0] rev_d
);
    always_comb begin
        rev_d = rev_q;
        if (idx_step) begin
            rev_d = idx_down ? rev_q - 1'b1 : rev_q + 1'b1;
        end else if (wrap_en && ovf) begin
            rev_d = rev_q + 1'b1;
        end else if (wrap_en && unf) begin
            rev_d = rev_q - 1'b1;
        end
    end
endmodule

// File: rtl/prc_abs.sv
module prc_abs #(
    parameter int W = 16
) (
    input  logic [W-1:0]   pos,
    input  logic [W-1:0]   rev,
    input  logic [W-1:0]   max_pos,
    input  logic           wrap_en,
    output logic [2*W-1:0] abs_pos
);
    localparam int AW = 2 * W;
    logic [AW-1:0] span;
    logic [AW-1:0] rev_x;
    logic [AW-1:0] pos_x;

    always_comb begin
        pos_x   = {{W{1'b0}}, pos};
        rev_x   = {{W{1'b0}}, rev};
        span    = {{W{1'b0}}, max_pos} + 1'b1;
        abs_pos = wrap_en ? pos_x + rev_x * span : pos_x;
    end
endmodule

// File: rtl/pos_rev_counter.sv
module pos_rev_counter
    import prc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_up_i,
    input  logic             cnt_dn_i,
    input  logic             ab_both_i,
    input  logic             index_i,
    input  logic [1:0]       rev_mode_i,
    input  logic             clr_gate_i,
    input  logic [W-1:0]     max_pos_i,
    input  logic             flag_wr_i,
    input  logic [2:0]       flag_wdata_i,
    output logic [W-1:0]     pos_o,
    output logic [W-1:0]     rev_o,
    output logic [2*W-1:0]   abs_pos_o,
    output logic             dir_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             zidx_o
);
    typedef struct packed {
        logic [W-1:0]      pos;
        logic [W-1:0]      rev;
        logic              dir;
        logic [FLAG_N-1:0] flg;
    } state_t;

    state_t    st_d, st_q;
    rev_mode_e mode;
    logic      step_up, step_dn, idx_clr, idx_step, idx_down, wrap_en;
    logic      ovf_ev, unf_ev;
    logic [W-1:0] pos_nx, rev_nx;
    logic [FLAG_N-1:0] flag_set, flag_keep;

    always_comb begin
        mode     = rev_mode_e'(rev_mode_i);
        step_up  = cnt_up_i & ~cnt_dn_i & ~ab_both_i;
        step_dn  = cnt_dn_i & ~cnt_up_i & ~ab_both_i;
        wrap_en  = rev_mode_i[1];
        idx_clr  = index_i & clr_gate_i & (mode != REV_WRAP);
        idx_step = index_i & clr_gate_i & rev_mode_i[0];
        if (ab_both_i)    idx_down = st_q.dir;
        else if (step_dn) idx_down = 1'b1;
        else if (step_up) idx_down = 1'b0;
        else              idx_down = st_q.dir;
    end

    prc_pos_next #(.W(W)) u_pos (
        .pos_q        (st_q.pos),
        .max_pos      (max_pos_i),
        .step_up      (step_up),
        .step_dn      (step_dn),
        .idx_clr      (idx_clr),
        .run_past_max (mode == REV_INDEX),
        .pos_d        (pos_nx),
        .ovf          (ovf_ev),
        .unf          (unf_ev)
    );

    prc_rev_next #(.W(W)) u_rev (
        .rev_q    (st_q.rev),
        .idx_step (idx_step),
        .idx_down (idx_down),
        .wrap_en  (wrap_en),
        .ovf      (ovf_ev),
        .unf      (unf_ev),
        .rev_d    (rev_nx)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLAG_OVF]  = ovf_ev;
        flag_set[FLAG_UNF]  = unf_ev;
        flag_set[FLAG_ZIX]  = index_i;
        flag_keep           = flag_wr_i ? flag_wdata_i : '1;

        st_d     = st_q;
        st_d.pos = pos_nx;
        st_d.rev = rev_nx;
        if (step_dn)      st_d.dir = 1'b1;
        else if (step_up) st_d.dir = 1'b0;
        st_d.flg = (st_q.flg & flag_keep) | flag_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    prc_abs #(.W(W)) u_abs (
        .pos     (st_q.pos),
        .rev     (st_q.rev),
        .max_pos (max_pos_i),
        .wrap_en (wrap_en),
        .abs_pos (abs_pos_o)
    );

    assign pos_o  = st_q.pos;
    assign rev_o  = st_q.rev;
    assign dir_o  = st_q.dir;
    assign ovf_o  = st_q.flg[FLAG_OVF];
    assign unf_o  = st_q.flg[FLAG_UNF];
    assign zidx_o = st_q.flg[FLAG_ZIX];
endmodule

// File: rtl/prc_check.sv
module prc_check #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_up_i,
    input logic         cnt_dn_i,
    input logic         ab_both_i,
    input logic         index_i,
    input logic [1:0]   rev_mode_i,
    input logic         clr_gate_i,
    input logic [W-1:0] max_pos_i,
    input logic         flag_wr_i,
    input logic [2:0]   flag_wdata_i,
    input logic [W-1:0] pos_o,
    input logic [W-1:0] rev_o,
    input logic         ovf_o,
    input logic         unf_o,
    input logic         zidx_o
);
    logic no_clr;
    assign no_clr = !(index_i && clr_gate_i && rev_mode_i != 2'b10);

    p_ovf_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_up_i && !cnt_dn_i && !ab_both_i && no_clr && rev_mode_i != 2'b01
         && pos_o == max_pos_i) |=> (pos_o == '0 && ovf_o));

    p_unf_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_dn_i && !cnt_up_i && !ab_both_i && no_clr && pos_o == '0)
        |=> (pos_o == $past(max_pos_i) && unf_o));

    p_rev_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_mode_i == 2'b00) |=> (rev_o == $past(rev_o)));

    p_idx_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_mode_i == 2'b10 && index_i && !cnt_up_i && !cnt_dn_i)
        |=> ($stable(pos_o) && $stable(rev_o)));

    p_zidx_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        index_i |=> zidx_o);

    p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !(flag_wr_i && !flag_wdata_i[0])) |=> ovf_o);

    p_unf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_o && !(flag_wr_i && !flag_wdata_i[1])) |=> unf_o);
endmodule

bind pos_rev_counter prc_check #(.W(W)) u_chk (.*);

// File: tb/pos_rev_counter_test.sv
module pos_rev_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_up_i = 0, cnt_dn_i = 0, ab_both_i = 0, index_i = 0;
    logic [1:0]  rev_mode_i = 2'b00;
    logic        clr_gate_i = 1'b1;
    logic [15:0] max_pos_i = 16'd5;
    logic        flag_wr_i = 1'b0;
    logic [2:0]  flag_wdata_i = 3'b111;
    logic [15:0] pos_o, rev_o;
    logic [31:0] abs_pos_o;
    logic        dir_o, ovf_o, unf_o, zidx_o;

    int checks = 0;
    int fails  = 0;

    logic [67:0] exp_q[$];
    string       tag_q[$];

    logic [15:0] m_pos = 0, m_rev = 0;
    logic        m_dir = 0;
    logic [2:0]  m_flg = 0;

    pos_rev_counter uut (.*);

    always #5 clk = ~clk;

    function automatic logic [67:0] pack_out(input logic [15:0] p, input logic [15:0] r,
                                             input logic [31:0] a, input logic d,
                                             input logic [2:0] f);
        return {p, r, a, d, f};
    endfunction

    function automatic logic [31:0] model_abs();
        if (rev_mode_i[1])
            return {16'd0, m_pos} + {16'd0, m_rev} * ({16'd0, max_pos_i} + 32'd1);
        return {16'd0, m_pos};
    endfunction

    task automatic compare(input string tag, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus plus its expected result
    task automatic step(input string tag, input logic u, input logic d, input logic b,
                        input logic z, input logic wr, input logic [2:0] wd);
        logic cu, cd, clr, zdn, so, su;
        logic [2:0] keep, set;
        @(negedge clk);
        cnt_up_i = u; cnt_dn_i = d; ab_both_i = b; index_i = z;
        flag_wr_i = wr; flag_wdata_i = wd;
        cu  = u && !d && !b;
        cd  = d && !u && !b;
        clr = z && clr_gate_i && rev_mode_i != 2'b10;
        zdn = b ? m_dir : (cd ? 1'b1 : (cu ? 1'b0 : m_dir));
        so = 0; su = 0;
        if (clr) m_pos = 0;
        else if (cu) begin
            if (m_pos == max_pos_i) begin
                so = 1;
                m_pos = (rev_mode_i == 2'b01) ? m_pos + 16'd1 : 16'd0;
            end else m_pos = m_pos + 16'd1;
        end else if (cd) begin
            if (m_pos == 0) begin su = 1; m_pos = max_pos_i; end
            else m_pos = m_pos - 16'd1;
        end
        if (z && clr_gate_i && rev_mode_i[0]) m_rev = zdn ? m_rev - 16'd1 : m_rev + 16'd1;
        else if (rev_mode_i[1] && so) m_rev = m_rev + 16'd1;
        else if (rev_mode_i[1] && su) m_rev = m_rev - 16'd1;
        if (cd) m_dir = 1; else if (cu) m_dir = 0;
        keep  = wr ? wd : 3'b111;
        set   = {z, su, so};
        m_flg = (m_flg & keep) | set;
        exp_q.push_back(pack_out(m_pos, m_rev, model_abs(), m_dir, m_flg));
        tag_q.push_back(tag);
    endtask

    task automatic cfg(input logic [1:0] mode, input logic [15:0] mx, input logic gate);
        @(negedge clk);
        cnt_up_i = 0; cnt_dn_i = 0; ab_both_i = 0; index_i = 0; flag_wr_i = 0;
        rev_mode_i = mode; max_pos_i = mx; clr_gate_i = gate;
    endtask

    // monitor: pops expectations after the state register has updated
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [67:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(t, pack_out(pos_o, rev_o, abs_pos_o, dir_o, {zidx_o, unf_o, ovf_o}), e);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R1 reset", pack_out(pos_o, rev_o, abs_pos_o, dir_o, {zidx_o, unf_o, ovf_o}), '0);

        // wrap mode: underflow, revolution wrap below zero
        cfg(2'b10, 16'd5, 1'b1);
        step("R2 R9 underflow", 0, 1, 0, 0, 0, 3'b111);
        for (int i = 0; i < 5; i++) step("R2 count down", 0, 1, 0, 0, 0, 3'b111);
        step("R2 R5 second underflow", 0, 1, 0, 0, 0, 3'b111);
        step("R1 R5 overflow", 1, 0, 0, 0, 0, 3'b111);
        step("R5 index ignored", 0, 0, 0, 1, 0, 3'b111);
        step("R11 clear all", 0, 0, 0, 0, 1, 3'b000);
        for (int i = 0; i < 5; i++) step("R12 abs while up", 1, 0, 0, 0, 0, 3'b111);
        step("R11 set wins", 1, 0, 0, 0, 1, 3'b000);
        step("R8 up and down cancel", 1, 1, 0, 0, 0, 3'b111);
        step("R11 partial clear", 0, 0, 0, 0, 1, 3'b110);

        // both sources
        cfg(2'b11, 16'd9, 1'b1);
        for (int i = 0; i < 3; i++) step("R6 R12 up", 1, 0, 0, 0, 0, 3'b111);
        step("R6 index clear", 0, 0, 0, 1, 0, 3'b111);
        for (int i = 0; i < 10; i++) step("R6 wrap up", 1, 0, 0, 0, 0, 3'b111);
        step("R6 up", 1, 0, 0, 0, 0, 3'b111);
        step("R7 index with opposite pulse", 0, 1, 0, 1, 0, 3'b111);
        step("R8 index both edges down", 1, 0, 1, 1, 0, 3'b111);
        step("R6 up", 1, 0, 0, 0, 0, 3'b111);
        step("R8 index both edges up", 0, 1, 1, 1, 0, 3'b111);
        step("R6 R2 underflow", 0, 1, 0, 0, 0, 3'b111);

        // revolution off
        cfg(2'b00, 16'd4, 1'b1);
        for (int i = 0; i < 3; i++) step("R3 up", 1, 0, 0, 0, 0, 3'b111);
        step("R3 index clears", 0, 0, 0, 1, 0, 3'b111);
        for (int i = 0; i < 5; i++) step("R1 R3 wrap", 1, 0, 0, 0, 0, 3'b111);
        step("R12 abs plain", 1, 0, 0, 0, 0, 3'b111);

        // index only
        cfg(2'b01, 16'd3, 1'b1);
        step("R4 index clear", 0, 0, 0, 1, 1, 3'b000);
        for (int i = 0; i < 5; i++) step("R4 count past max", 1, 0, 0, 0, 0, 3'b111);
        step("R4 index up", 0, 0, 0, 1, 0, 3'b111);
        step("R4 down", 0, 1, 0, 0, 0, 3'b111);
        step("R4 index down", 0, 0, 0, 1, 0, 3'b111);

        // clear gate low
        cfg(2'b11, 16'd9, 1'b0);
        step("R10 clear", 0, 0, 0, 0, 1, 3'b000);
        step("R10 up", 1, 0, 0, 0, 0, 3'b111);
        step("R10 index flag only", 1, 0, 0, 1, 0, 3'b111);
        step("R10 idle", 0, 0, 0, 0, 0, 3'b111);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule